// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Receiver

This block is one target in a chain of devices that share a single serial configuration stream. A host drives a common clock, a common data bit and a common active-low configure request to every target. Each target also has an active-low enable input. The first target's enable is tied low, and every other target's enable comes from the enable-out of the target before it. A target shifts in one bit on each rising clock edge while it is enabled. Once it has its full share of the stream, it lowers its enable-out. The next target then takes the following bit on the very next edge, so the host sees one unbroken stream.

Two lines are shared as wired-AND signals, one for status and one for done. The block models each as a drive-low enable output plus a sampled input that carries the resolved level of the line. A target that finds a checksum mismatch holds the status line low. While the status line is low, no target shifts, so the whole chain halts until the configure request is pulsed low. A target holds the done line low until its own share is complete. The line therefore rises only after the last target finishes, and at that point every target reports user mode together.

The serial stream has no back-pressure: every qualifying rising edge carries one bit, and no valid/ready handshake exists. Each target's share is `PAYLOAD_WORDS` data words followed by one check word. Every word is `WORD_W` bits long and is sent least significant bit first.

Top module: `cfg_chain_rx`

## Requirements
- R1: While `cfg_req_n` is low, `ceo_n` is 1, `status_drive_low` is 1, `done_drive_low` is 1 and `user_mode` is 0, and clock edges and data seen during that time leave no trace after release.
- R2: After `cfg_req_n` rises, `status_drive_low` stays 1 for exactly `HOLD_CYC` rising edges and then falls to 0; no bit is accepted during that interval.
- R3: A bit is taken only on a rising edge where the load phase has begun and `ce_n` is 0 and `status_line` is 1; a target whose `ce_n` is 1 counts no bits.
- R4: A share is `(PAYLOAD_WORDS+1)*WORD_W` bits, each word sent LSB first; the final word is the check word and must equal the bitwise XOR of all data words.
- R5: On the edge that takes the final bit with a matching check word, `ceo_n` goes to 0 and `done_drive_low` goes to 0 right after that edge. Both keep those values until `cfg_req_n` goes low.
- R6: A chained next target takes its first bit on the edge immediately after the handoff, so a continuous stream of two shares completes both targets with no bit lost or repeated.
- R7: On a check-word mismatch, `status_drive_low` becomes 1 right after the final edge while `ceo_n` and `done_drive_low` stay 1. This holds through any number of further edges until `cfg_req_n` is pulsed low.
- R8: Rising edges while `status_line` is 0 are not counted, so loading resumes where it stopped once the line is released.
- R9: `user_mode` is 1 exactly when the target has completed its share and `done_line` is 1.
- R10: Once complete, further clock edges and data bits change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock; bits are taken on rising edges |
| cfg_req_n | input | 1 | Shared active-low configure request; asynchronously restarts the target |
| ce_n | input | 1 | Active-low enable from the previous target (tied low on the first) |
| din | input | 1 | Shared serial data bit |
| status_line | input | 1 | Resolved level of the wired-AND status line |
| done_line | input | 1 | Resolved level of the wired-AND done line |
| ceo_n | output | 1 | Active-low enable passed to the next target |
| status_drive_low | output | 1 | Pulls the shared status line low when 1 |
| done_drive_low | output | 1 | Pulls the shared done line low when 1 |
| user_mode | output | 1 | Target is complete and the whole chain has released done |

## Verification
The hardest situation to reach from the ports is the exact bit boundary where one target hands over to the next. A single missing or extra bit there looks correct on the first target and only shows up downstream. The bench therefore wires two targets into a chain with their status and done lines resolved as wired-AND. It streams two shares back to back and checks each target's enable-out one bit before its expected completion and again at completion. A stall of the chain caused by another device is reproduced by having the bench pull the status line itself partway through a share. The bench then confirms that completion moves back by exactly the number of edges it blocked.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } cfg_state_e;
endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int WORD_W     = 8,
  parameter int TOTAL_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  output logic word_end,
  output logic last_bit
);
  localparam int CNT_W = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1;
  localparam int POS_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [CNT_W-1:0] bit_cnt;
  logic [POS_W-1:0] pos_cnt;

  assign last_bit = (bit_cnt == CNT_W'(TOTAL_BITS - 1));
  assign word_end = (pos_cnt == POS_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      pos_cnt <= '0;
    end else if (shift_en) begin
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      pos_cnt <= word_end ? '0 : pos_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_check_acc.sv
module cfg_check_acc #(
  parameter int WORD_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  input  logic word_end,
  output logic sum_zero
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] word_now;
  logic [WORD_W-1:0] acc_next;

  assign word_now = {din, shreg[WORD_W-1:1]};
  assign acc_next = acc ^ word_now;
  assign sum_zero = (acc_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      acc   <= '0;
    end else if (shift_en) begin
      shreg <= word_now;
      if (word_end) acc <= acc_next;
    end
  end
endmodule

// File: rtl/cfg_ctrl_fsm.sv
module cfg_ctrl_fsm
  import cfg_chain_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       status_line,
  input  logic       last_bit,
  input  logic       sum_zero,
  output logic       shift_en,
  output cfg_state_e state
);
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [HOLD_W-1:0] hold_cnt;

  assign shift_en = (state == ST_LOAD) && !ce_n && status_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HOLD;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) state <= ST_LOAD;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        ST_LOAD: begin
          if (shift_en && last_bit) state <= sum_zero ? ST_DONE : ST_FAULT;
        end
        ST_DONE:  state <= ST_DONE;
        ST_FAULT: state <= ST_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter int WORD_W        = 8,
  parameter int PAYLOAD_WORDS = 3,
  parameter int HOLD_CYC      = 4
) (
  input  logic clk,
  input  logic cfg_req_n,
  input  logic ce_n,
  input  logic din,
  input  logic status_line,
  input  logic done_line,
  output logic ceo_n,
  output logic status_drive_low,
  output logic done_drive_low,
  output logic user_mode
);
  localparam int TOTAL_BITS = (PAYLOAD_WORDS + 1) * WORD_W;

  cfg_state_e state;
  logic       shift_en;
  logic       word_end;
  logic       last_bit;
  logic       sum_zero;

  cfg_bit_counter #(.WORD_W(WORD_W), .TOTAL_BITS(TOTAL_BITS)) u_cnt (
    .clk      (clk),
    .rst_n    (cfg_req_n),
    .shift_en (shift_en),
    .word_end (word_end),
    .last_bit (last_bit)
  );

  cfg_check_acc #(.WORD_W(WORD_W)) u_acc (
    .clk      (clk),
    .rst_n    (cfg_req_n),
    .shift_en (shift_en),
    .din      (din),
    .word_end (word_end),
    .sum_zero (sum_zero)
  );

  cfg_ctrl_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (cfg_req_n),
    .ce_n        (ce_n),
    .status_line (status_line),
    .last_bit    (last_bit),
    .sum_zero    (sum_zero),
    .shift_en    (shift_en),
    .state       (state)
  );

  assign ceo_n            = (state != ST_DONE);
  assign done_drive_low   = (state != ST_DONE);
  assign status_drive_low = (state == ST_HOLD) || (state == ST_FAULT);
  assign user_mode        = (state == ST_DONE) && done_line;
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk (
  input logic clk,
  input logic cfg_req_n,
  input logic ce_n,
  input logic status_line,
  input logic done_line,
  input logic ceo_n,
  input logic status_drive_low,
  input logic done_drive_low,
  input logic user_mode
);
  assert_reset_outputs_R1: assert property (@(posedge clk)
    !cfg_req_n |-> (ceo_n && status_drive_low && done_drive_low && !user_mode));

  assert_no_take_disabled_R3: assert property (@(posedge clk) disable iff (!cfg_req_n)
    (ce_n && ceo_n) |=> ceo_n);

  assert_handoff_sticky_R5: assert property (@(posedge clk) disable iff (!cfg_req_n)
    !ceo_n |=> !ceo_n);

  assert_fault_blocks_handoff_R7: assert property (@(posedge clk) disable iff (!cfg_req_n)
    status_drive_low |-> (ceo_n && done_drive_low));

  assert_halt_on_status_R8: assert property (@(posedge clk) disable iff (!cfg_req_n)
    (!status_line && ceo_n) |=> ceo_n);

  assert_user_mode_R9: assert property (@(posedge clk) disable iff (!cfg_req_n)
    user_mode |-> (done_line && !ceo_n && !done_drive_low));
endmodule

bind cfg_chain_rx cfg_chain_rx_chk u_chk (
  .clk              (clk),
  .cfg_req_n        (cfg_req_n),
  .ce_n             (ce_n),
  .status_line      (status_line),
  .done_line        (done_line),
  .ceo_n            (ceo_n),
  .status_drive_low (status_drive_low),
  .done_drive_low   (done_drive_low),
  .user_mode        (user_mode)
);

// File: tb/cfg_chain_rx_tb.sv
`timescale 1ns/1ps
module cfg_chain_rx_tb;
  localparam int HOLD = 4;
  localparam int NV   = 4;
  // {check-word corruption, data word 2, data word 1, data word 0}
  localparam logic [31:0] VEC [NV] = '{
    32'h00_A5_3C_11, 32'h00_FF_00_FF, 32'h01_12_34_56, 32'h80_00_00_00
  };

  logic clk = 1'b0;
  logic cfg_req_n = 1'b0;
  logic din = 1'b0;
  logic tb_status_pull = 1'b0;
  logic tb_done_pull = 1'b0;
  logic ceo0, sdl0, ddl0, um0, ceo1, sdl1, ddl1, um1;
  logic status_line, done_line;
  int n_checks = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  assign status_line = ~(sdl0 | sdl1 | tb_status_pull);
  assign done_line   = ~(ddl0 | ddl1 | tb_done_pull);

  cfg_chain_rx #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .cfg_req_n(cfg_req_n), .ce_n(1'b0), .din(din),
    .status_line(status_line), .done_line(done_line),
    .ceo_n(ceo0), .status_drive_low(sdl0), .done_drive_low(ddl0), .user_mode(um0));

  cfg_chain_rx #(.HOLD_CYC(HOLD)) u_next (
    .clk(clk), .cfg_req_n(cfg_req_n), .ce_n(ceo0), .din(din),
    .status_line(status_line), .done_line(done_line),
    .ceo_n(ceo1), .status_drive_low(sdl1), .done_drive_low(ddl1), .user_mode(um1));

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [31:0] v);
    return {v[31:24] ^ v[23:16] ^ v[15:8] ^ v[7:0], v[23:0]};
  endfunction

  task automatic send_bits(input logic [31:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      din = v[i];
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    cfg_req_n = 1'b0;
    repeat (2) @(negedge clk);
    cfg_req_n = 1'b1;
    repeat (HOLD) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] g0, g1, s;
    logic ok;
    g0 = mk(32'h00_C3_5A_96);
    g1 = mk(32'h00_0F_E1_7B);
    repeat (3) @(negedge clk);
    // R1: reset state, then clock and data ignored while request is low
    check("R1 ceo_n", ceo0, 1'b1);
    check("R1 status", sdl0, 1'b1);
    check("R1 done", ddl0, 1'b1);
    check("R1 user_mode", um0, 1'b0);
    for (int i = 0; i < 40; i++) begin din = i[0]; @(negedge clk); end
    check("R1 ceo_n after activity", ceo0, 1'b1);
    // R2: reset interval
    cfg_req_n = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    check("R2 status held", sdl0, 1'b1);
    @(negedge clk);
    check("R2 status released", sdl0, 1'b0);
    // R5/R3/R6/R9: continuous stream across two targets
    send_bits(g0, 0, 30);
    check("R5 no early handoff", ceo0, 1'b1);
    send_bits(g0, 31, 31);
    check("R5 handoff", ceo0, 1'b0);
    check("R5 done released", ddl0, 1'b0);
    check("R9 waits for chain", um0, 1'b0);
    check("R3 next not complete", ceo1, 1'b1);
    send_bits(g1, 0, 30);
    check("R6 no bit lost", ceo1, 1'b1);
    send_bits(g1, 31, 31);
    check("R6 next complete", ceo1, 1'b0);
    check("R9 user_mode first", um0, 1'b1);
    check("R9 user_mode next", um1, 1'b1);
    // R10: extra bits after completion
    send_bits(32'hDEAD_BEEF, 0, 15);
    check("R10 ceo_n stays", ceo0, 1'b0);
    check("R10 user_mode stays", um0, 1'b1);
    check("R10 status free", sdl0, 1'b0);
    tb_done_pull = 1'b1;
    #1;
    check("R9 done line low", um0, 1'b0);
    tb_done_pull = 1'b0;
    // R4/R5/R7: vector table
    for (int k = 0; k < NV; k++) begin
      s  = mk(VEC[k]);
      ok = (VEC[k][31:24] == 8'h00);
      do_reset();
      send_bits(s, 0, 30);
      check("R4 pre-final", ceo0, 1'b1);
      send_bits(s, 31, 31);
      check("R4 ceo_n", ceo0, !ok);
      check("R7 status", sdl0, !ok);
      check("R5 done", ddl0, !ok);
    end
    // R7: fault is sticky until the request is pulsed
    send_bits(32'hFFFF_0000, 0, 31);
    send_bits(32'h1234_5678, 0, 7);
    check("R7 fault held", sdl0, 1'b1);
    check("R7 no handoff", ceo0, 1'b1);
    do_reset();
    check("R7 cleared by request", sdl0, 1'b0);
    // R8: external status pull halts shifting
    tb_status_pull = 1'b1;
    send_bits(32'hFFFF_FFFF, 0, 9);
    tb_status_pull = 1'b0;
    send_bits(g0, 0, 30);
    check("R8 halted edges not counted", ceo0, 1'b1);
    send_bits(g0, 31, 31);
    check("R8 completes after resume", ceo0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule